// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Flush Commands

This block is a small, fully associative cache of page translations. Each line holds a valid bit, a 2-bit address-space tag, a 20-bit virtual page number, a 20-bit physical frame number and a 3-bit attribute field. An external page walker installs lines through a refill port. A client presents an address-space tag and a virtual page number on the lookup port and gets a registered response one cycle later.

Software controls the block through a write-only register port with three targets: a translation enable bit, a configuration word, and a 32-bit flush command. Writing the flush command invalidates matching lines in a single cycle. A flush can target every line, one 4 MiB section or one 16 KiB group, and it can be limited to one address space. Two counters record hits and misses while statistics are enabled. When translation is off, the block passes the virtual page straight through as the frame number.

Top module: `asid_tlb`

## Requirements
- R1: After reset the configuration word reads 0x20000010 (bit 29 hit-under-miss, bits 5:0 active line count 16), translation is disabled, both counters are zero, no line is valid and `rsp_valid` is low. A register write with `reg_sel` 0 sets the enable from `reg_wdata[0]`, and `reg_sel` 1 loads the whole configuration word. Both take effect in the following cycle.
- R2: A lookup with translation enabled produces, in the next cycle, `rsp_valid` high and `rsp_hit` high with the line's frame number and attributes when a valid line has the same tag and page. Otherwise `rsp_hit` is low and the frame and attributes read zero. Lines of other tags never hit.
- R3: A refill whose tag and page already sit in a valid line overwrites that line instead of taking a new one, so later lookups return the new frame. A refill becomes visible to lookups from the following cycle.
- R4: A refill that allocates takes the round-robin victim among the active lines, given by configuration bits 5:0. A value of 0 or more than 16 means all 16 lines. A victim pointer at or beyond the active count restarts at line 0.
- R5: A flush command (`reg_sel` 2) with type bits 1:0 = 0 invalidates every line.
- R6: Type 2 invalidates lines whose page bits 19:10 (VA bits 31:22) equal command bits 19:10.
- R7: Type 3 invalidates lines whose page bits 19:2 (VA bits 31:14) equal command bits 19:2.
- R8: With command bit 31 set, only lines whose tag equals command bits 30:29 are flushed. With bit 31 clear, all tags are candidates.
- R9: A flush command of type 1 changes no line.
- R10: A lookup in the same cycle as a matching flush sees the line as already invalid and misses. A refill in that cycle is applied after the flush.
- R11: With translation disabled, a lookup returns `rsp_hit` high, frame equal to the page, attributes zero, and changes neither counter.
- R12: With translation enabled, each lookup adds one to the hit or the miss counter, but only while configuration bit 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Target: 0 enable, 1 configuration, 2 flush command, 3 none |
| reg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 2 | Lookup address-space tag |
| lk_vpn | input | 20 | Lookup virtual page number |
| fill_valid | input | 1 | Refill request from the walker |
| fill_asid | input | 2 | Refill tag |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_pfn | input | 20 | Refill frame number |
| fill_attr | input | 3 | Refill attributes |
| rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| rsp_hit | output | 1 | Translation found (or pass-through) |
| rsp_pfn | output | 20 | Translated frame number |
| rsp_attr | output | 3 | Translated attributes |
| xlat_en | output | 1 | Current translation enable |
| tlb_cfg | output | 32 | Current configuration word |
| hit_cnt | output | 32 | Hit counter |
| miss_cnt | output | 32 | Miss counter |

## Verification
A stale valid bit or a wrong tag in a line shows as a false hit, with a wrong frame, on the first lookup of that page after the flush or refill. Broken flush matching shows the same way, within one cycle of the flush. A wrong round-robin pointer only shows after enough refills to wrap the active set, so the bench narrows the active count to make an eviction visible within three refills. Counter faults show at once, because both counters are compared against a model after every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        SEL_XLAT  = 2'd0,
        SEL_CFG   = 2'd1,
        SEL_FLUSH = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        FL_ALL     = 2'd0,
        FL_RSVD    = 2'd1,
        FL_SECTION = 2'd2,
        FL_GROUP   = 2'd3
    } flush_kind_e;

    localparam int unsigned CFG_STATS_BIT   = 31;
    localparam int unsigned CFG_ACT_W       = 6;
    localparam logic [31:0] CFG_RESET       = 32'h2000_0010;
    localparam int unsigned FL_ASID_EN_BIT  = 31;
    localparam int unsigned FL_ASID_LSB     = 29;
    localparam int unsigned FL_SEC_LSB      = 10;
    localparam int unsigned FL_GRP_LSB      = 2;

endpackage

// File: rtl/tlb_flush_match.sv
module tlb_flush_match #(
    parameter int unsigned N       = 16,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned ASID_W  = 2,
    parameter int unsigned SEC_LSB = 10,
    parameter int unsigned GRP_LSB = 2
) (
    input  logic                     flush_req,
    input  tlb_pkg::flush_kind_e     kind,
    input  logic                     asid_qual,
    input  logic [ASID_W-1:0]        asid_key,
    input  logic [VPN_W-1:GRP_LSB]   vpn_key,
    input  logic [N-1:0]             ent_vld,
    input  logic [ASID_W-1:0]        ent_asid [N],
    input  logic [VPN_W-1:0]         ent_vpn  [N],
    output logic [N-1:0]             kill
);
    import tlb_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic asid_ok;
        logic page_ok;
        always_comb begin
            asid_ok = !asid_qual || (ent_asid[i] == asid_key);
            case (kind)
                FL_ALL:     page_ok = 1'b1;
                FL_SECTION: page_ok = (ent_vpn[i][VPN_W-1:SEC_LSB] == vpn_key[VPN_W-1:SEC_LSB]);
                FL_GROUP:   page_ok = (ent_vpn[i][VPN_W-1:GRP_LSB] == vpn_key);
                default:    page_ok = 1'b0;
            endcase
            kill[i] = flush_req && ent_vld[i] && asid_ok && page_ok;
        end
    end

endmodule

// File: rtl/tlb_cam_lookup.sv
module tlb_cam_lookup #(
    parameter int unsigned N      = 16,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned ASID_W = 2,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        ent_vld,
    input  logic [ASID_W-1:0]   ent_asid [N],
    input  logic [VPN_W-1:0]    ent_vpn  [N],
    input  logic [ASID_W-1:0]   key_asid,
    input  logic [VPN_W-1:0]    key_vpn,
    output logic                hit,
    output logic [IDX_W-1:0]    idx
);
    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = ent_vld[i] && (ent_asid[i] == key_asid) && (ent_vpn[i] == key_vpn);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_rr_victim.sv
module tlb_rr_victim #(
    parameter int unsigned N     = 16,
    parameter int unsigned ACT_W = 6,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [ACT_W-1:0]  act_field,
    output logic [IDX_W-1:0]  victim
);
    logic [IDX_W-1:0] ptr_d, ptr_q;
    logic [IDX_W:0]   act;
    logic [IDX_W:0]   nxt;

    always_comb begin
        if (act_field == '0 || int'(act_field) > int'(N)) act = (IDX_W+1)'(N);
        else act = (IDX_W+1)'(act_field);
        victim = ({1'b0, ptr_q} >= act) ? '0 : ptr_q;
        nxt    = {1'b0, victim} + (IDX_W+1)'(1);
        ptr_d  = ptr_q;
        if (advance) ptr_d = (nxt == act) ? '0 : nxt[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
    parameter int unsigned N      = 16,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned PFN_W  = 20,
    parameter int unsigned ASID_W = 2,
    parameter int unsigned ATTR_W = 3,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [ATTR_W-1:0] fill_attr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              xlat_en,
    output logic [31:0]       tlb_cfg,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);
    import tlb_pkg::*;

    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [31:0]       cfg;
        logic              xen;
        logic [CNT_W-1:0]  hits;
        logic [CNT_W-1:0]  misses;
        logic              rv;
        logic              rhit;
        logic [PFN_W-1:0]  rpfn;
        logic [ATTR_W-1:0] rattr;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [N-1:0]        vld_d, vld_q;
    logic [ASID_W-1:0]   asid_d [N];
    logic [ASID_W-1:0]   asid_q [N];
    logic [VPN_W-1:0]    vpn_d  [N];
    logic [VPN_W-1:0]    vpn_q  [N];
    logic [PFN_W-1:0]    pfn_d  [N];
    logic [PFN_W-1:0]    pfn_q  [N];
    logic [ATTR_W-1:0]   attr_d [N];
    logic [ATTR_W-1:0]   attr_q [N];

    logic                flush_req;
    logic [N-1:0]        kill;
    logic [N-1:0]        live;
    logic                lk_hit, dup_hit;
    logic [IDX_W-1:0]    lk_idx, dup_idx, victim, fill_idx;

    assign flush_req = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_FLUSH);
    assign live      = vld_q & ~kill;

    tlb_flush_match #(
        .N(N), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .SEC_LSB(FL_SEC_LSB), .GRP_LSB(FL_GRP_LSB)
    ) u_flush (
        .flush_req (flush_req),
        .kind      (flush_kind_e'(reg_wdata[1:0])),
        .asid_qual (reg_wdata[FL_ASID_EN_BIT]),
        .asid_key  (reg_wdata[FL_ASID_LSB +: ASID_W]),
        .vpn_key   (reg_wdata[VPN_W-1:FL_GRP_LSB]),
        .ent_vld   (vld_q),
        .ent_asid  (asid_q),
        .ent_vpn   (vpn_q),
        .kill      (kill)
    );

    tlb_cam_lookup #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lookup (
        .ent_vld  (live),
        .ent_asid (asid_q),
        .ent_vpn  (vpn_q),
        .key_asid (lk_asid),
        .key_vpn  (lk_vpn),
        .hit      (lk_hit),
        .idx      (lk_idx)
    );

    tlb_cam_lookup #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_dup (
        .ent_vld  (vld_q),
        .ent_asid (asid_q),
        .ent_vpn  (vpn_q),
        .key_asid (fill_asid),
        .key_vpn  (fill_vpn),
        .hit      (dup_hit),
        .idx      (dup_idx)
    );

    tlb_rr_victim #(.N(N), .ACT_W(CFG_ACT_W)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (fill_valid && !dup_hit),
        .act_field (st_q.cfg[CFG_ACT_W-1:0]),
        .victim    (victim)
    );

    assign fill_idx = dup_hit ? dup_idx : victim;

    always_comb begin
        st_d   = st_q;
        vld_d  = live;
        asid_d = asid_q;
        vpn_d  = vpn_q;
        pfn_d  = pfn_q;
        attr_d = attr_q;

        if (fill_valid) begin
            vld_d[fill_idx]  = 1'b1;
            asid_d[fill_idx] = fill_asid;
            vpn_d[fill_idx]  = fill_vpn;
            pfn_d[fill_idx]  = fill_pfn;
            attr_d[fill_idx] = fill_attr;
        end

        st_d.rv    = lk_valid;
        st_d.rhit  = 1'b0;
        st_d.rpfn  = '0;
        st_d.rattr = '0;
        if (lk_valid) begin
            if (!st_q.xen) begin
                st_d.rhit = 1'b1;
                st_d.rpfn = PFN_W'(lk_vpn);
            end else begin
                st_d.rhit = lk_hit;
                if (lk_hit) begin
                    st_d.rpfn  = pfn_q[lk_idx];
                    st_d.rattr = attr_q[lk_idx];
                end
                if (st_q.cfg[CFG_STATS_BIT]) begin
                    if (lk_hit) st_d.hits   = st_q.hits + CNT_W'(1);
                    else        st_d.misses = st_q.misses + CNT_W'(1);
                end
            end
        end

        if (reg_wr_en) begin
            case (reg_sel_e'(reg_sel))
                SEL_XLAT: st_d.xen = reg_wdata[0];
                SEL_CFG:  st_d.cfg = reg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= CFG_RESET;
            vld_q    <= '0;
        end else begin
            st_q  <= st_d;
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        asid_q <= asid_d;
        vpn_q  <= vpn_d;
        pfn_q  <= pfn_d;
        attr_q <= attr_d;
    end

    assign rsp_valid = st_q.rv;
    assign rsp_hit   = st_q.rhit;
    assign rsp_pfn   = st_q.rpfn;
    assign rsp_attr  = st_q.rattr;
    assign xlat_en   = st_q.xen;
    assign tlb_cfg   = st_q.cfg;
    assign hit_cnt   = st_q.hits;
    assign miss_cnt  = st_q.misses;

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
    parameter int unsigned VPN_W = 20,
    parameter int unsigned PFN_W = 20,
    parameter int unsigned CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [1:0]        reg_sel,
    input logic [31:0]       reg_wdata,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PFN_W-1:0]  rsp_pfn,
    input logic              xlat_en,
    input logic [31:0]       tlb_cfg,
    input logic [CNT_W-1:0]  hit_cnt,
    input logic [CNT_W-1:0]  miss_cnt
);
    // R2: a response appears exactly one cycle after each lookup
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R11: pass-through while translation is off
    p_passthrough_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !xlat_en) |=> (rsp_hit && rsp_pfn == PFN_W'($past(lk_vpn))));
    p_no_count_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_en |=> ($stable(hit_cnt) && $stable(miss_cnt)));

    // R12: counters frozen when statistics are off, and step by at most one
    p_stats_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tlb_cfg[31] |=> ($stable(hit_cnt) && $stable(miss_cnt)));
    p_one_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (($stable(hit_cnt) && $stable(miss_cnt)) ||
                      (hit_cnt == $past(hit_cnt) + CNT_W'(1) && $stable(miss_cnt)) ||
                      (miss_cnt == $past(miss_cnt) + CNT_W'(1) && $stable(hit_cnt))));

    // R10: a global flush in the lookup cycle forces a miss
    p_flush_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && xlat_en && reg_wr_en && reg_sel == 2'd2 && reg_wdata[1:0] == 2'd0
         && !reg_wdata[31]) |=> !rsp_hit);

endmodule

bind asid_tlb asid_tlb_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .lk_valid  (lk_valid),
    .lk_vpn    (lk_vpn),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_pfn   (rsp_pfn),
    .xlat_en   (xlat_en),
    .tlb_cfg   (tlb_cfg),
    .hit_cnt   (hit_cnt),
    .miss_cnt  (miss_cnt)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [1:0]  lk_asid = '0;
    logic [19:0] lk_vpn = '0;
    logic        fill_valid = 1'b0;
    logic [1:0]  fill_asid = '0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [2:0]  fill_attr = '0;
    logic        rsp_valid, rsp_hit, xlat_en;
    logic [19:0] rsp_pfn;
    logic [2:0]  rsp_attr;
    logic [31:0] tlb_cfg, hit_cnt, miss_cnt;

    asid_tlb u_asid_tlb (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";

    // model state
    bit          m_vld [N];
    logic [1:0]  m_asid [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_pfn [N];
    logic [2:0]  m_attr [N];
    logic [31:0] m_cfg = 32'h2000_0010;
    bit          m_xen = 0;
    logic [31:0] m_hits = 0, m_miss = 0;
    int          m_rr = 0;
    bit          e_rv, e_hit;
    logic [19:0] e_pfn;
    logic [2:0]  e_attr;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit fl_hit(int i, logic [31:0] c);
        bit a_ok, p_ok;
        a_ok = !c[31] || (m_asid[i] == c[30:29]);
        case (c[1:0])
            2'd0: p_ok = 1;
            2'd2: p_ok = (m_vpn[i][19:10] == c[19:10]);
            2'd3: p_ok = (m_vpn[i][19:2] == c[19:2]);
            default: p_ok = 0;
        endcase
        return m_vld[i] && a_ok && p_ok;
    endfunction

    function automatic logic [31:0] mk_flush(int kind, bit aq, logic [1:0] a, logic [19:0] v);
        logic [31:0] c;
        c = {aq, a, 27'd0, 2'(kind)};
        if (kind == 2) c[19:10] = v[19:10];
        if (kind == 3) c[19:2] = v[19:2];
        return c;
    endfunction

    task automatic model_eval();
        bit k [N];
        bit fl;
        int hit_i, dup_i, act, vic;
        fl = reg_wr_en && reg_sel == 2'd2;
        for (int i = 0; i < N; i++) k[i] = fl && fl_hit(i, reg_wdata);
        hit_i = -1;
        for (int i = N - 1; i >= 0; i--)
            if (m_vld[i] && !k[i] && m_asid[i] == lk_asid && m_vpn[i] == lk_vpn) hit_i = i;
        dup_i = -1;
        for (int i = N - 1; i >= 0; i--)
            if (m_vld[i] && m_asid[i] == fill_asid && m_vpn[i] == fill_vpn) dup_i = i;
        e_rv = lk_valid; e_hit = 0; e_pfn = 0; e_attr = 0;
        if (lk_valid) begin
            if (!m_xen) begin
                e_hit = 1; e_pfn = lk_vpn;
            end else begin
                e_hit = (hit_i >= 0);
                if (e_hit) begin e_pfn = m_pfn[hit_i]; e_attr = m_attr[hit_i]; end
                if (m_cfg[31]) begin
                    if (e_hit) m_hits++; else m_miss++;
                end
            end
        end
        for (int i = 0; i < N; i++) if (k[i]) m_vld[i] = 0;
        if (fill_valid) begin
            act = int'(m_cfg[5:0]);
            if (act == 0 || act > N) act = N;
            if (dup_i >= 0) vic = dup_i;
            else begin
                vic = (m_rr >= act) ? 0 : m_rr;
                m_rr = (vic + 1 == act) ? 0 : vic + 1;
            end
            m_vld[vic] = 1; m_asid[vic] = fill_asid; m_vpn[vic] = fill_vpn;
            m_pfn[vic] = fill_pfn; m_attr[vic] = fill_attr;
        end
        if (reg_wr_en && reg_sel == 2'd0) m_xen = reg_wdata[0];
        if (reg_wr_en && reg_sel == 2'd1) m_cfg = reg_wdata;
    endtask

    task automatic run_cycle();
        model_eval();
        @(posedge clk);
        #2;
        chk(cur_req, 32'(rsp_valid), 32'(e_rv), "rsp_valid");
        chk(cur_req, 32'(rsp_hit), 32'(e_hit), "rsp_hit");
        chk(cur_req, 32'(rsp_pfn), 32'(e_pfn), "rsp_pfn");
        chk(cur_req, 32'(rsp_attr), 32'(e_attr), "rsp_attr");
        chk(cur_req, hit_cnt, m_hits, "hit_cnt");
        chk(cur_req, miss_cnt, m_miss, "miss_cnt");
        chk(cur_req, tlb_cfg, m_cfg, "tlb_cfg");
        chk(cur_req, 32'(xlat_en), 32'(m_xen), "xlat_en");
        @(negedge clk);
        reg_wr_en = 0; lk_valid = 0; fill_valid = 0;
    endtask

    task automatic do_reg(logic [1:0] s, logic [31:0] d);
        reg_wr_en = 1; reg_sel = s; reg_wdata = d; run_cycle();
    endtask
    task automatic do_lookup(logic [1:0] a, logic [19:0] v);
        lk_valid = 1; lk_asid = a; lk_vpn = v; run_cycle();
    endtask
    task automatic do_fill(logic [1:0] a, logic [19:0] v, logic [19:0] p, logic [2:0] at);
        fill_valid = 1; fill_asid = a; fill_vpn = v; fill_pfn = p; fill_attr = at; run_cycle();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int h0, m0;
        for (int i = 0; i < N; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", tlb_cfg, 32'h2000_0010, "cfg reset");
        chk("R1", 32'(xlat_en), 0, "xlat reset");
        chk("R1", hit_cnt, 0, "hits reset");
        chk("R1", miss_cnt, 0, "miss reset");
        chk("R1", 32'(rsp_valid), 0, "rsp reset");

        do_reg(2'd1, 32'hA000_0010);
        cur_req = "R11";
        do_lookup(2'd0, 20'h12345);
        chk("R11", 32'(rsp_hit), 1, "passthrough hit");
        chk("R11", 32'(rsp_pfn), 32'h12345, "passthrough pfn");
        chk("R11", miss_cnt, 0, "no count");

        cur_req = "R1";
        do_reg(2'd0, 32'h1);
        do_lookup(2'd0, 20'h12345);
        chk("R1", 32'(rsp_hit), 0, "empty after reset");
        chk("R12", miss_cnt, 1, "miss counted");

        cur_req = "R2";
        do_fill(2'd1, 20'h00404, 20'hABCDE, 3'd5);
        do_lookup(2'd1, 20'h00404);
        chk("R2", 32'(rsp_pfn), 32'hABCDE, "hit pfn");
        chk("R2", 32'(rsp_attr), 5, "hit attr");
        do_lookup(2'd2, 20'h00404);
        chk("R2", 32'(rsp_hit), 0, "other asid");

        cur_req = "R3";
        do_fill(2'd1, 20'h00404, 20'h11111, 3'd2);
        do_lookup(2'd1, 20'h00404);
        chk("R3", 32'(rsp_pfn), 32'h11111, "in-place refill");

        cur_req = "R4";
        do_reg(2'd1, 32'hA000_0002);
        do_reg(2'd2, mk_flush(0, 0, 0, 0));
        do_fill(2'd0, 20'h00100, 20'h0000A, 3'd1);
        do_fill(2'd0, 20'h00200, 20'h0000B, 3'd1);
        do_fill(2'd0, 20'h00300, 20'h0000C, 3'd1);
        do_lookup(2'd0, 20'h00100);
        chk("R4", 32'(rsp_hit), 0, "evicted oldest");
        do_lookup(2'd0, 20'h00200);
        chk("R4", 32'(rsp_hit), 1, "second kept");
        do_lookup(2'd0, 20'h00300);
        chk("R4", 32'(rsp_hit), 1, "third present");

        cur_req = "R9";
        do_reg(2'd1, 32'hA000_0010);
        do_reg(2'd2, mk_flush(0, 0, 0, 0));
        do_fill(2'd0, 20'h00C08, 20'h00001, 3'd0);
        do_reg(2'd2, mk_flush(1, 0, 0, 20'h00C08));
        do_lookup(2'd0, 20'h00C08);
        chk("R9", 32'(rsp_hit), 1, "type1 no effect");

        cur_req = "R6";
        do_fill(2'd0, 20'h00C30, 20'h00002, 3'd0);
        do_fill(2'd0, 20'h01008, 20'h00003, 3'd0);
        do_reg(2'd2, mk_flush(2, 0, 0, 20'h00C00));
        do_lookup(2'd0, 20'h00C08);
        chk("R6", 32'(rsp_hit), 0, "section flushed a");
        do_lookup(2'd0, 20'h00C30);
        chk("R6", 32'(rsp_hit), 0, "section flushed b");
        do_lookup(2'd0, 20'h01008);
        chk("R6", 32'(rsp_hit), 1, "other section kept");

        cur_req = "R7";
        do_fill(2'd0, 20'h00C08, 20'h00004, 3'd0);
        do_fill(2'd0, 20'h00C09, 20'h00005, 3'd0);
        do_fill(2'd0, 20'h00C10, 20'h00006, 3'd0);
        do_reg(2'd2, mk_flush(3, 0, 0, 20'h00C0B));
        do_lookup(2'd0, 20'h00C09);
        chk("R7", 32'(rsp_hit), 0, "group flushed");
        do_lookup(2'd0, 20'h00C10);
        chk("R7", 32'(rsp_hit), 1, "other group kept");

        cur_req = "R8";
        do_fill(2'd1, 20'h00500, 20'h00007, 3'd0);
        do_fill(2'd2, 20'h00500, 20'h00008, 3'd0);
        do_reg(2'd2, mk_flush(0, 1, 2'd2, 0));
        do_lookup(2'd1, 20'h00500);
        chk("R8", 32'(rsp_hit), 1, "other asid kept");
        do_lookup(2'd2, 20'h00500);
        chk("R8", 32'(rsp_hit), 0, "asid flushed");

        cur_req = "R5";
        do_reg(2'd2, mk_flush(0, 0, 0, 0));
        do_lookup(2'd1, 20'h00500);
        chk("R5", 32'(rsp_hit), 0, "flush all");

        cur_req = "R10";
        do_fill(2'd3, 20'h00777, 20'h00009, 3'd0);
        lk_valid = 1; lk_asid = 2'd3; lk_vpn = 20'h00777;
        do_reg(2'd2, mk_flush(0, 0, 0, 0));
        chk("R10", 32'(rsp_hit), 0, "same-cycle flush");

        cur_req = "R12";
        do_fill(2'd3, 20'h00777, 20'h00009, 3'd0);
        do_reg(2'd1, 32'h2000_0010);
        h0 = int'(hit_cnt); m0 = int'(miss_cnt);
        do_lookup(2'd3, 20'h00777);
        do_lookup(2'd3, 20'h00778);
        chk("R12", hit_cnt, 32'(h0), "hits frozen");
        chk("R12", miss_cnt, 32'(m0), "misses frozen");

        cur_req = "R2";
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            lk_valid = ($urandom % 10) < 7;
            lk_asid = 2'($urandom); lk_vpn = 20'((($urandom % 4) << 10) | ($urandom % 64));
            fill_valid = ($urandom % 10) < 3;
            fill_asid = 2'($urandom); fill_vpn = 20'((($urandom % 4) << 10) | ($urandom % 64));
            fill_pfn = 20'($urandom); fill_attr = 3'($urandom);
            reg_wr_en = ($urandom % 100) < 15;
            case ($urandom % 8)
                0: begin reg_sel = 2'd1; reg_wdata = {1'($urandom), 2'b01, 23'd0, 6'($urandom % 21)}; end
                1: begin reg_sel = 2'd0; reg_wdata = 32'(($urandom % 4) != 0); end
                default: begin
                    reg_sel = 2'd2;
                    reg_wdata = mk_flush(int'($urandom % 4), 1'($urandom), 2'($urandom), lk_vpn);
                end
            endcase
            run_cycle();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule